// File: doc/BRIEF.md
# Debounced Input Change-of-State Detector

This block sits behind a small general-purpose input port. Seven raw pins are brought into the clock domain through a two-flop synchroniser. The synchronised levels can be read at any time as an 8-bit word whose top bit is always 1.

The four lowest pins also feed change-of-state detectors. Each detector looks at its pin only when the slow sampling strobe (`sample_stb`) is high. A new level is accepted only when two back-to-back strobes both see it. An accepted transition in either direction latches a sticky change flag.

A read pulse returns the change word and clears the flags one cycle later. An event that lands in the same cycle as the read survives the clear. A per-flag enable mask ORs the selected flags into one interrupt request.

Each detector is a four-state machine:
- `F_HIGH`: stable high.
- `F_FALL_PEND`: one low sample seen.
- `F_LOW`: stable low.
- `F_RISE_PEND`: one high sample seen.

Its transitions are:
- strobe with the opposite level: stable state to pending state;
- strobe confirming the new level: pending state to the opposite stable state, raising the event;
- strobe seeing the old level again: pending state back to its stable state, rejecting the glitch;
- no strobe: hold the current state.

Top module: `inport_cos_top`

## Requirements
- R1: `port_data[7]` reads 1. `port_data[6:0]` carry the pin levels (high pin = 1), delayed by two clock edges through the synchroniser.
- R2: Pins 4 to 6 have no detector. Changing them never sets a flag or alters `chg_data`.
- R3: A detector samples only in cycles with `sample_stb` high. A new level needs two consecutive strobes that both show it, so one strobe alone changes nothing visible.
- R4: If the strobe after a first deviating sample shows the old level again, the change is dropped and no flag is set.
- R5: An accepted falling or rising transition on detected pin n sets `chg_data[n]` (bits 3:0). The flag is visible in the cycle after the confirming strobe.
- R6: `chg_data[7:4]` give the filtered (accepted) levels of pins 3 to 0. Bit 4 is pin 0.
- R7: In a cycle with `rd_chg` high, `chg_data` shows the flags before clearing. All flags read 0 in the next cycle unless a new event arrived.
- R8: An event whose confirming strobe coincides with `rd_chg` remains set after the read.
- R9: `irq` is high exactly when some flag n is set while `irq_en[n]` is 1.
- R10: After reset, all filtered levels are 1 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 7 | Raw asynchronous input pins |
| sample_stb | input | 1 | One-cycle sampling strobe for the detectors |
| rd_chg | input | 1 | Read pulse for the change word; clears the flags |
| irq_en | input | 4 | Per-flag interrupt enable |
| port_data | output | 8 | Direct port read: {1, synchronised pins} |
| chg_data | output | 8 | {filtered levels 3:0, change flags 3:0} |
| irq | output | 1 | Combined interrupt request |

## Verification
Pin changes reach `port_data` two clock edges after they are driven. Every scenario therefore holds a pin for two cycles before it asserts any strobe.

A confirming strobe updates both the filtered level and the flag at the same edge. The checks sample `chg_data` half a cycle after that edge, and also after the first, non-confirming strobe to show nothing moved.

The clear is checked the same way: the pre-clear value is sampled while `rd_chg` is high, and the cleared value half a cycle after the next edge. `irq` follows the flags combinationally, so it is checked in the same half cycles as `chg_data`.

// File: rtl/inport_cos_pkg.sv
package inport_cos_pkg;
    typedef enum logic [1:0] {
        F_LOW       = 2'd0,
        F_RISE_PEND = 2'd1,
        F_HIGH      = 2'd2,
        F_FALL_PEND = 2'd3
    } filt_state_e;
endpackage

// File: rtl/inport_sync2.sv
module inport_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;
endmodule

// File: rtl/inport_cos_filter.sv
module inport_cos_filter
    import inport_cos_pkg::*;
#(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic din,
    output logic lvl,
    output logic evt
);
    filt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_LVL ? F_HIGH : F_LOW;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_LOW:       if (stb && din)  state_d = F_RISE_PEND;
            F_RISE_PEND: if (stb)         state_d = din ? F_HIGH : F_LOW;
            F_HIGH:      if (stb && !din) state_d = F_FALL_PEND;
            F_FALL_PEND: if (stb)         state_d = din ? F_HIGH : F_LOW;
            default:                      state_d = F_HIGH;
        endcase
    end

    // Outputs
    always_comb begin
        lvl = 1'b0;
        evt = 1'b0;
        unique case (state_q)
            F_LOW:       lvl = 1'b0;
            F_RISE_PEND: begin lvl = 1'b0; evt = stb && din;  end
            F_HIGH:      lvl = 1'b1;
            F_FALL_PEND: begin lvl = 1'b1; evt = stb && !din; end
            default:     lvl = 1'b1;
        endcase
    end

    AST_LVL_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(lvl)); // R3
    AST_EVT_FLIPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (lvl != $past(lvl))); // R5
endmodule

// File: rtl/inport_cos_flags.sv
module inport_cos_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd,
    input  logic [N-1:0] en,
    output logic [N-1:0] flag,
    output logic         irq
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & {N{!rd}}) | evt;
    end

    assign flag = flag_q;
    assign irq  = |(flag_q & en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_EVT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && rd) |=> flag_q[i]); // R8
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !evt[i]) |=> !flag_q[i]); // R7
    end
endmodule

// File: rtl/inport_cos_top.sv
module inport_cos_top #(
    parameter int N_PINS = 7,
    parameter int N_DET  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        pin_in,
    input  logic              sample_stb,
    input  logic              rd_chg,
    input  logic [3:0]        irq_en,
    output logic [7:0]        port_data,
    output logic [7:0]        chg_data,
    output logic              irq
);
    localparam int PORT_W = N_PINS + 1;
    localparam int CHG_W  = 2 * N_DET;

    logic [N_PINS-1:0] pin_s;
    logic [N_DET-1:0]  lvl;
    logic [N_DET-1:0]  evt;
    logic [N_DET-1:0]  flag;

    inport_sync2 #(.W(N_PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_s)
    );

    for (genvar i = 0; i < N_DET; i++) begin : g_det
        inport_cos_filter #(.RST_LVL(1'b1)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (sample_stb),
            .din   (pin_s[i]),
            .lvl   (lvl[i]),
            .evt   (evt[i])
        );
    end

    inport_cos_flags #(.N(N_DET)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .rd    (rd_chg),
        .en    (irq_en),
        .flag  (flag),
        .irq   (irq)
    );

    assign port_data = PORT_W'({1'b1, pin_s});
    assign chg_data  = CHG_W'({lvl, flag});

    AST_FLAG_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && !rd_chg) |=> $stable(chg_data)); // R3
endmodule

// File: tb/test_inport_cos_top.sv
module test_inport_cos_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pin_in = 7'h7F;
    logic       sample_stb = 1'b0;
    logic       rd_chg = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic [7:0] port_data;
    logic [7:0] chg_data;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    inport_cos_top i_inport_cos_top (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sample_stb(sample_stb),
        .rd_chg(rd_chg), .irq_en(irq_en), .port_data(port_data),
        .chg_data(chg_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each helper starts and ends at a negedge
    task automatic set_pins(input logic [6:0] v);
        pin_in = v;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic strobe();
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        #1;
    endtask

    task automatic read_chg(input string req, input logic [7:0] exp_rd, input logic [7:0] exp_after);
        rd_chg = 1'b1;
        #1;
        chk(req, chg_data, exp_rd);
        @(negedge clk);
        rd_chg = 1'b0;
        #1;
        chk(req, chg_data, exp_after);
    endtask

    task automatic t_reset();
        chk("R10 levels/flags", chg_data, 8'hF0);
        chk("R1 reset port", port_data, 8'hFF);
        chk("R10 irq", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_port();
        set_pins(7'h55);
        chk("R1 port read", port_data, 8'hD5);
        chk("R3 no strobe no change", chg_data, 8'hF0);
        set_pins(7'h7F);
    endtask

    task automatic t_fall();
        set_pins(7'h7E);
        strobe();
        chk("R3 one sample", chg_data, 8'hF0);
        strobe();
        chk("R5 R6 fall", chg_data, 8'hE1);
        read_chg("R7 read clear", 8'hE1, 8'hE0);
    endtask

    task automatic t_glitch();
        set_pins(7'h7C);
        strobe();
        set_pins(7'h7E);
        strobe();
        strobe();
        chk("R4 glitch rejected", chg_data, 8'hE0);
    endtask

    task automatic t_rise();
        set_pins(7'h7F);
        strobe();
        strobe();
        chk("R5 rise", chg_data, 8'hF1);
        read_chg("R7 read clear 2", 8'hF1, 8'hF0);
    endtask

    task automatic t_upper();
        set_pins(7'h0F);
        strobe();
        strobe();
        chk("R2 upper pins ignored", chg_data, 8'hF0);
        chk("R1 upper port", port_data, 8'h8F);
        set_pins(7'h7F);
        strobe();
        strobe();
        chk("R2 upper pins back", chg_data, 8'hF0);
    endtask

    task automatic t_irq();
        irq_en = 4'b0100;
        set_pins(7'h77);
        strobe();
        strobe();
        chk("R9 masked", {chg_data, 7'h0, irq} >> 0 == 0 ? 8'h00 : {7'h0, irq}, 8'h00);
        chk("R5 bit3", chg_data, 8'h78);
        set_pins(7'h73);
        strobe();
        strobe();
        chk("R9 enabled", {7'h0, irq}, 8'h01);
        read_chg("R7 read", 8'h3C, 8'h30);
        chk("R9 cleared", {7'h0, irq}, 8'h00);
        irq_en = 4'h0;
    endtask

    task automatic t_collide();
        set_pins(7'h7B);
        strobe();
        sample_stb = 1'b1;
        rd_chg = 1'b1;
        #1;
        chk("R8 pre-clear", chg_data, 8'h30);
        @(negedge clk);
        sample_stb = 1'b0;
        rd_chg = 1'b0;
        #1;
        chk("R8 kept", chg_data, 8'hB8);
        read_chg("R7 final", 8'hB8, 8'hB0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_port();
        t_fall();
        t_glitch();
        t_rise();
        t_upper();
        t_irq();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule